// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block steps a processor-style system from battery power-up to run mode. It runs on an always-on, low-frequency clock. It watches three asynchronous, active-low inputs: an external reset, a battery-fault flag and a supply-fault flag. From these it drives a system enable, a power enable and an active-low core reset.

The sequence starts only when the external reset is released while the battery is healthy. Two programmable waits follow. The first ends by raising the system enable. The second ends by raising the power enable, after which the core supplies come up. The block then waits a bounded time for the supply-fault flag to clear. If the flag clears in time, the core reset is released and the system runs. If the window expires first, both enables drop, a sticky timeout flag is set and the block goes back to idle.

All delays are parameters counted in clock ticks. The present state is brought out so the sequence can be observed.

Top module: `por_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to idle. In idle `state_o` is 0, both enables are low, `core_rst_n_o` is low and `sup_timeout_o` is low.
- R2: Each of the three asynchronous inputs passes through a two-flop synchronizer. A change driven before clock edge k acts on the state machine at edge k+2, so `state_o` shows the effect after edge k+2.
- R3: A sequence starts only on a release of the synchronized external reset (low one cycle, high the next) while the synchronized battery-fault input is high. A release with the battery input low leaves the block in idle. The battery input rising later does not start a sequence until there is another release.
- R4: The system-delay state (code 1) lasts exactly `SYS_CYC` cycles with all outputs low. Leaving it raises `sys_en_o`.
- R5: The power-delay state (code 2) lasts exactly `PWR_CYC` cycles with only `sys_en_o` high. Leaving it raises `pwr_en_o`.
- R6: The supply-fault input is ignored in every state before the supply-wait state (code 3). A high value seen earlier does not shorten either delay.
- R7: In the supply-wait state, a high synchronized supply-fault input moves the block to run (code 4) at the next edge, and `core_rst_n_o` goes high. This takes priority over a timeout expiring at the same edge. Run is left only through the external reset or `rst_n`.
- R8: If the supply-fault input stays low for `WIN_CYC` cycles in the supply-wait state, the block enters the fault state (code 5) with all enables low for one cycle and then returns to idle. It does not restart without a fresh release.
- R9: A low synchronized external reset in any state sends the block to idle at the next edge.
- R10: `sup_timeout_o` goes high on entry to the fault state. It stays high, even through later successful sequences, until `rst_n` is asserted.
- R11: `state_o` encodes idle=0, system delay=1, power delay=2, supply wait=3, run=4, fault=5.
- R12: `core_rst_n_o` high implies both enables are high, and `pwr_en_o` high implies `sys_en_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ext_rst_n_i | input | 1 | Asynchronous external reset, active low |
| batt_fault_n_i | input | 1 | Asynchronous battery fault, active low |
| sup_fault_n_i | input | 1 | Asynchronous supply fault, active low |
| sys_en_o | output | 1 | System enable |
| pwr_en_o | output | 1 | Core power enable |
| core_rst_n_o | output | 1 | Active-low reset to the core; high in run |
| sup_timeout_o | output | 1 | Sticky supply-window timeout flag |
| state_o | output | 3 | Present sequencer state code |

## Verification
Every input change takes two edges to cross its synchronizer and acts on the state register at the third edge. All outputs decode the state register directly, so each result appears after the third edge following the stimulus. Stimulus is driven on falling edges. A behavioural model keeps a two-deep queue for the synchronizers plus a state and a tick count, and its outputs are compared with the design's on every falling edge. Directed checks sample at exactly the third falling edge after a change. Phase lengths are measured as runs of consecutive samples. The race between supply-good and the end of the window is timed so that both land on the same edge.

// File: rtl/por_pkg.sv
// Package: shared state encoding for the power-on sequencer.
// Assumes: codes are visible on the top-level state output and must not change.
package por_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYSDLY  = 3'd1,
        ST_PWRDLY  = 3'd2,
        ST_WAITSUP = 3'd3,
        ST_RUN     = 3'd4,
        ST_FAULT   = 3'd5
    } por_state_e;
endpackage

// File: rtl/por_sync.sv
// Module: por_sync
// Two-stage synchronizer for a vector of independent asynchronous bits.
// Assumes: bits are unrelated (no bus coherency); reset value is all zero,
// which reads as "reset asserted / fault present" for active-low inputs.
module por_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_i;
    end

    // Remaining stages shift the captured value toward the output.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/por_timer.sv
// Module: por_timer
// Up-counter that restarts on clear and holds once it reaches a given last value.
// Assumes: last value is held stable while counting; clear wins over counting.
module por_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt;

    assign done_o = (cnt == last_i);

    // Count ticks since the last clear, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clear_i) cnt <= '0;
        else if (!done_o) cnt <= cnt + CNT_W'(1);
    end

    // R4
    timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt == '0));
endmodule

// File: rtl/por_fsm.sv
// Module: por_fsm
// Sequencer state machine: release check, two timed delays, supply window, run.
// Assumes: all inputs are already synchronized; the timer is cleared whenever
// the state changes, so each timed state starts counting from zero.
module por_fsm
    import por_pkg::*;
#(
    parameter int SYS_CYC = 328,
    parameter int PWR_CYC = 328,
    parameter int WIN_CYC = 4096,
    parameter int CNT_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_ok_i,
    input  logic             batt_ok_i,
    input  logic             sup_ok_i,
    input  logic             tmr_done_i,
    output logic             tmr_clear_o,
    output logic [CNT_W-1:0] tmr_last_o,
    output logic [2:0]       state_o,
    output logic             sys_en_o,
    output logic             pwr_en_o,
    output logic             core_rst_n_o,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] SYS_LAST = CNT_W'(SYS_CYC - 1);
    localparam logic [CNT_W-1:0] PWR_LAST = CNT_W'(PWR_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_CYC - 1);

    por_state_e state, nxt;
    logic       ext_prev;
    logic       timeout_q;

    // Next-state decision; external reset overrides every state.
    always_comb begin
        nxt = state;
        if (!ext_ok_i) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (!ext_prev && batt_ok_i) nxt = ST_SYSDLY;
                ST_SYSDLY:  if (tmr_done_i) nxt = ST_PWRDLY;
                ST_PWRDLY:  if (tmr_done_i) nxt = ST_WAITSUP;
                ST_WAITSUP: begin
                    if (sup_ok_i)        nxt = ST_RUN;
                    else if (tmr_done_i) nxt = ST_FAULT;
                end
                ST_RUN:     nxt = ST_RUN;
                ST_FAULT:   nxt = ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // Choose the terminal count for the state being timed.
    always_comb begin
        unique case (state)
            ST_SYSDLY: tmr_last_o = SYS_LAST;
            ST_PWRDLY: tmr_last_o = PWR_LAST;
            default:   tmr_last_o = WIN_LAST;
        endcase
    end

    assign tmr_clear_o = (nxt != state);

    // State register plus the previous external-reset level for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ext_prev <= 1'b0;
        end else begin
            state    <= nxt;
            ext_prev <= ext_ok_i;
        end
    end

    // Sticky timeout flag, cleared only by the block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                timeout_q <= 1'b0;
        else if (nxt == ST_FAULT)  timeout_q <= 1'b1;
    end

    assign state_o      = state;
    assign sys_en_o     = (state == ST_PWRDLY) || (state == ST_WAITSUP) || (state == ST_RUN);
    assign pwr_en_o     = (state == ST_WAITSUP) || (state == ST_RUN);
    assign core_rst_n_o = (state == ST_RUN);
    assign timeout_o    = timeout_q;

    // R3
    batt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !batt_ok_i) |=> (state == ST_IDLE));
    // R7
    supply_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITSUP && sup_ok_i && ext_ok_i) |=> (state == ST_RUN));
    // R8
    fault_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |=> (state == ST_IDLE && timeout_o));
    // R9
    ext_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ok_i |=> (state == ST_IDLE));
    // R10
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> timeout_o);
    // R12
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_n_o |-> (pwr_en_o && sys_en_o)) and (pwr_en_o |-> sys_en_o));
endmodule

// File: rtl/por_sequencer.sv
// Module: por_sequencer (top)
// Power-on reset sequencer: synchronizes the raw inputs, times the delays and
// drives the enables and the core reset.
// Assumes: clk is always running; SYS_CYC, PWR_CYC and WIN_CYC are at least 1.
module por_sequencer #(
    parameter int SYS_CYC = 328,
    parameter int PWR_CYC = 328,
    parameter int WIN_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst_n_i,
    input  logic       batt_fault_n_i,
    input  logic       sup_fault_n_i,
    output logic       sys_en_o,
    output logic       pwr_en_o,
    output logic       core_rst_n_o,
    output logic       sup_timeout_o,
    output logic [2:0] state_o
);
    localparam int MAX_A   = (SYS_CYC > PWR_CYC) ? SYS_CYC : PWR_CYC;
    localparam int MAX_CYC = (MAX_A > WIN_CYC) ? MAX_A : WIN_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [2:0]       raw, synced;
    logic             tmr_clear, tmr_done;
    logic [CNT_W-1:0] tmr_last;

    assign raw = {sup_fault_n_i, batt_fault_n_i, ext_rst_n_i};

    por_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    por_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .last_i  (tmr_last),
        .done_o  (tmr_done)
    );

    por_fsm #(
        .SYS_CYC (SYS_CYC),
        .PWR_CYC (PWR_CYC),
        .WIN_CYC (WIN_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_ok_i     (synced[0]),
        .batt_ok_i    (synced[1]),
        .sup_ok_i     (synced[2]),
        .tmr_done_i   (tmr_done),
        .tmr_clear_o  (tmr_clear),
        .tmr_last_o   (tmr_last),
        .state_o      (state_o),
        .sys_en_o     (sys_en_o),
        .pwr_en_o     (pwr_en_o),
        .core_rst_n_o (core_rst_n_o),
        .timeout_o    (sup_timeout_o)
    );
endmodule

// File: tb/por_sequencer_bench.sv
module por_sequencer_bench;
    localparam int SYS = 5;
    localparam int PWR = 4;
    localparam int WIN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext = 1'b0, batt = 1'b0, sup = 1'b0;
    logic       sys_en, pwr_en, core_rst_n, tmo;
    logic [2:0] st;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    por_sequencer #(.SYS_CYC(SYS), .PWR_CYC(PWR), .WIN_CYC(WIN)) u_por_sequencer (
        .clk(clk), .rst_n(rst_n), .ext_rst_n_i(ext), .batt_fault_n_i(batt),
        .sup_fault_n_i(sup), .sys_en_o(sys_en), .pwr_en_o(pwr_en),
        .core_rst_n_o(core_rst_n), .sup_timeout_o(tmo), .state_o(st)
    );

    always #2 clk = ~clk;

    // Behavioural reference: sync queue, state number, tick count, sticky flag.
    logic [2:0] q[$];
    int  m_st = 0, m_cnt = 0, m_to = 0, m_prev = 0;
    bit  started = 0;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_to = 0; m_prev = 0;
            q = {3'b000, 3'b000};
        end else begin
            logic [2:0] s;
            int n;
            s = q[0];
            n = m_st;
            if (!s[0]) n = 0;
            else if (m_st == 0) begin if (m_prev == 0 && s[1]) n = 1; end
            else if (m_st == 1) begin if (m_cnt == SYS - 1) n = 2; end
            else if (m_st == 2) begin if (m_cnt == PWR - 1) n = 3; end
            else if (m_st == 3) begin
                if (s[2]) n = 4;
                else if (m_cnt == WIN - 1) n = 5;
            end
            else if (m_st == 5) n = 0;
            if (n != m_st) m_cnt = 0; else m_cnt++;
            if (n == 5) m_to = 1;
            m_prev = s[0];
            m_st = n;
            void'(q.pop_front());
            q.push_back({sup, batt, ext});
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R11 state", int'(st), m_st);
            chk("R4 sys_en", int'(sys_en), int'(m_st == 2 || m_st == 3 || m_st == 4));
            chk("R5 pwr_en", int'(pwr_en), int'(m_st == 3 || m_st == 4));
            chk("R7 core_rst_n", int'(core_rst_n), int'(m_st == 4));
            chk("R10 timeout", int'(tmo), m_to);
            chk("R12 order", int'(core_rst_n && !(pwr_en && sys_en)) + int'(pwr_en && !sys_en), 0);
        end
    end

    // Measure how long each delay state lasts.
    int sys_run = 0, sys_len = 0, pwr_run = 0, pwr_len = 0;
    always @(negedge clk) begin
        if (st == 3'd1) sys_run++; else begin if (sys_run != 0) sys_len = sys_run; sys_run = 0; end
        if (st == 3'd2) pwr_run++; else begin if (pwr_run != 0) pwr_len = pwr_run; pwr_run = 0; end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            summary();
        end
    end

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_state(int s);
        for (int i = 0; i < 300; i++) begin
            if (int'(st) == s) return;
            @(negedge clk);
        end
    endtask

    task automatic fresh_release();
        ext = 1'b0;
        cycles(3);
        ext = 1'b1;
    endtask

    initial begin
        cycles(3);
        // R1 reset state
        chk("R1 state", int'(st), 0);
        chk("R1 outputs", int'({sys_en, pwr_en, core_rst_n, tmo}), 0);
        rst_n = 1'b1;

        // R3: release while battery fault active
        ext = 1'b1; batt = 1'b0;
        cycles(10);
        chk("R3 no start", int'(st), 0);
        batt = 1'b1;
        cycles(10);
        chk("R3 needs fresh release", int'(st), 0);

        // R2 and R6: supply already good during the delays
        sup = 1'b1;
        ext = 1'b0;
        cycles(3);
        ext = 1'b1;
        cycles(2);
        chk("R2 not yet", int'(st), 0);
        cycles(1);
        chk("R2 started", int'(st), 1);
        wait_state(4);
        chk("R4 sys length", sys_len, SYS);
        chk("R5 pwr length", pwr_len, PWR);
        chk("R6 delays kept", sys_len + pwr_len, SYS + PWR);
        chk("R7 run", int'(core_rst_n), 1);

        // R7: run ignores later supply fault
        sup = 1'b0;
        cycles(6);
        chk("R7 stays run", int'(st), 4);

        // R9: external reset from run
        ext = 1'b0;
        cycles(2);
        chk("R9 not yet", int'(st), 4);
        cycles(1);
        chk("R9 idle", int'(st), 0);
        chk("R9 outputs", int'({sys_en, pwr_en, core_rst_n}), 0);

        // R8: supply window expires
        ext = 1'b1;
        wait_state(5);
        chk("R8 fault", int'({sys_en, pwr_en}), 0);
        chk("R8 flag", int'(tmo), 1);
        cycles(1);
        chk("R8 back idle", int'(st), 0);
        cycles(8);
        chk("R8 no restart", int'(st), 0);

        // R10: successful sequence keeps the flag
        sup = 1'b1;
        fresh_release();
        wait_state(4);
        chk("R10 still set", int'(tmo), 1);

        // R7: supply good on the same edge the window ends
        ext = 1'b0;
        cycles(3);
        sup = 1'b0;
        ext = 1'b1;
        wait_state(3);
        cycles(WIN - 3);
        sup = 1'b1;
        cycles(3);
        chk("R7 priority", int'(st), 4);

        // R9: external reset during the system delay
        fresh_release();
        wait_state(1);
        ext = 1'b0;
        cycles(3);
        chk("R9 from delay", int'(st), 0);

        // R1/R10: block reset clears the flag
        rst_n = 1'b0;
        cycles(1);
        chk("R10 cleared", int'(tmo), 0);
        chk("R1 idle", int'(st), 0);
        rst_n = 1'b1;
        cycles(2);
        summary();
    end
endmodule